// File: doc/BRIEF.md
# Page Table Walk Step Unit

This block carries out a single step of a multi-level page table walk that is sequenced by refill software. Each step is one of two operations. A directory step takes a base value and a level number, picks the index for that level out of the faulting virtual address, forms the physical address of the next directory entry, and reads that entry. A leaf step either fetches the even or odd page table entry of a pair, or, when the base is a huge-page entry found earlier in the walk, splits it into an even or odd half without touching memory. A leaf step writes its result into one of two refill low registers and updates a refill page-size register.

The field position and width for each level, and the entry width, come in on two configuration register inputs. Memory is reached through a read request port with a valid/ready handshake and a one-beat response. An operation is presented as a one-cycle `op_valid_i` pulse while the unit is idle, and it ends with a one-cycle `done_o` pulse.

Top module: `ptw_step_unit`

## Requirements
- R1: While reset is active, and after it is released, `done_o` and `rd_req_valid_o` are 0 and `dir_result_o`, `refill_lo0_o`, `refill_lo1_o` and `refill_ps_o` are 0.
- R2: A directory step at level L (1 to 4) that is not huge reads the 64-bit word at (masked base) OR (index << 3*(code+1)). Here index = (fault VA >> pos_L) & (2^wid_L − 1) and code = `cfg_lo_i[49:48]`. Each level has a 16-bit slot with pos at bits [5:0] and wid at bits [12:8]: the leaf slot is at `cfg_lo_i[15:0]`, level 1 at `[31:16]`, level 2 at `[47:32]`, level 3 at `cfg_hi_i[15:0]` and level 4 at `cfg_hi_i[31:16]`. The word read appears on `dir_result_o`.
- R3: A directory step with level 0, 5, 6 or 7 returns the raw base on `dir_result_o` and issues no read.
- R4: A directory step whose base has the huge bit (bit 6) set issues no read. At level 4, or when the base's level field (bits 14:13) is nonzero, it returns the raw base. Otherwise it returns the raw base with the level field set to the step level.
- R5: A leaf step with a non-huge base reads the entry at index (fault VA >> leaf pos, masked to leaf wid) with bit 0 cleared, plus 1 when `op_odd_i` is 1, using the R2 address rule. `refill_ps_o` becomes the leaf pos.
- R6: A leaf step with a huge base issues no read. Its result is the masked base with the level field and huge bit cleared and, if bit 12 is set, bit 12 cleared and bit 6 set. `refill_ps_o` becomes pos + wid − 1 of the level named by the base's level field (level 0 uses the leaf slot). For the odd half, 1 << that page size is added to the result.
- R7: A leaf result goes to `refill_lo0_o` for an even step and to `refill_lo1_o` for an odd step, and the other refill low register keeps its value. A directory step leaves all three refill outputs unchanged.
- R8: The base is masked to the physical address width (48 bits by default) before it forms an address or a leaf result, and every word read is masked the same way.
- R9: Once raised, `rd_req_valid_o` stays high with a stable `rd_req_addr_o` until `rd_req_ready_i` is seen high. Only one read is outstanding at a time.
- R10: `done_o` is a one-cycle pulse. It comes one cycle after the read response for steps that read, and one cycle after acceptance for steps that do not. `op_valid_i` is ignored while a step is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Start a step (taken only when idle) |
| op_leaf_i | input | 1 | 0 = directory step, 1 = leaf step |
| op_level_i | input | 3 | Walk level for a directory step |
| op_odd_i | input | 1 | Leaf step selects the odd half |
| op_base_i | input | 64 | Directory base or entry value |
| fault_va_i | input | 64 | Faulting virtual address |
| cfg_lo_i | input | 64 | Leaf, level 1 and level 2 slots, entry width code |
| cfg_hi_i | input | 32 | Level 3 and level 4 slots |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_req_addr_o | output | 64 | Physical address to read |
| rd_rsp_valid_i | input | 1 | Read response valid |
| rd_rsp_data_i | input | 64 | Read response data |
| done_o | output | 1 | Step complete pulse |
| dir_result_o | output | 64 | Result of the last directory step |
| refill_lo0_o | output | 64 | Even refill low register |
| refill_lo1_o | output | 64 | Odd refill low register |
| refill_ps_o | output | 6 | Refill page-size field |

## Verification
The bench builds the unit with its default parameters: a 48-bit physical width, the level field at bits 14:13, the huge bit and the global bit both at bit 6, and the huge-global bit at bit 12. Bases and memory words are given bits above bit 47, so the masking is visible at the outputs. Because the huge bit and the global bit share bit 6, the bench can see the relocation of the huge-global bit. With 9-bit level fields at positions 12, 21, 30 and 39, huge pages at levels 1 and 2 give distinct page sizes. The bench also varies the entry width code, the request stall and the response latency.

// File: rtl/ptw_step_pkg.sv
package ptw_step_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } ptw_state_e;

  // position / width pair of one walk level
  typedef struct packed {
    logic [5:0] pos;
    logic [4:0] wid;
  } lvl_field_t;

  localparam int SLOT_W    = 16;
  localparam int NUM_SLOTS = 5;   // leaf + four directory levels
  localparam int EWC_LSB   = 48;  // entry width code inside cfg_lo

endpackage

// File: rtl/ptw_level_sel.sv
module ptw_level_sel
  import ptw_step_pkg::*;
(
  input  logic [63:0] cfg_lo,
  input  logic [31:0] cfg_hi,
  input  logic [2:0]  level,
  output lvl_field_t  fld
);

  logic [SLOT_W-1:0] slot [NUM_SLOTS];

  generate
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      if (k < 3) begin : g_lo
        assign slot[k] = cfg_lo[k*SLOT_W +: SLOT_W];
      end else begin : g_hi
        assign slot[k] = cfg_hi[(k-3)*SLOT_W +: SLOT_W];
      end
    end
  endgenerate

  logic [SLOT_W-1:0] pick;

  always_comb begin
    // levels outside 1..4 fall back to the leaf slot
    if (level >= 3'd1 && level <= 3'd4) pick = slot[level];
    else                                pick = slot[0];
    fld.pos = pick[5:0];
    fld.wid = pick[12:8];
  end

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_step_pkg::*;
(
  input  logic [63:0] base_m,
  input  logic [63:0] va,
  input  lvl_field_t  fld,
  input  logic [1:0]  ewc,
  input  logic        leaf_mode,
  input  logic        odd,
  output logic [63:0] addr
);

  logic [63:0] idx_mask;
  logic [63:0] idx_raw;
  logic [63:0] idx;
  logic [3:0]  shamt;

  always_comb begin
    idx_mask = (64'd1 << fld.wid) - 64'd1;
    idx_raw  = (va >> fld.pos) & idx_mask;
    if (leaf_mode) idx = {idx_raw[63:1], odd};
    else           idx = idx_raw;
    shamt = 4'(({2'b00, ewc} + 4'd1) * 4'd3);
    addr  = base_m | (idx << shamt);
  end

endmodule

// File: rtl/ptw_huge_split.sv
module ptw_huge_split
  import ptw_step_pkg::*;
#(
  parameter int LVL_LSB  = 13,
  parameter int LVL_W    = 2,
  parameter int HUGE_BIT = 6,
  parameter int HGLB_BIT = 12,
  parameter int GLB_BIT  = 6
) (
  input  logic [63:0] base_m,
  input  lvl_field_t  fld,
  input  logic        odd,
  output logic [63:0] entry,
  output logic [5:0]  ps
);

  logic [6:0]  ps_sum;
  logic [63:0] half;

  always_comb begin
    ps_sum = {1'b0, fld.pos} + {2'b00, fld.wid} - 7'd1;
    ps     = ps_sum[5:0];
    half   = base_m;
    half[LVL_LSB +: LVL_W] = '0;
    half[HUGE_BIT] = 1'b0;
    if (half[HGLB_BIT]) begin
      half[HGLB_BIT] = 1'b0;
      half[GLB_BIT]  = 1'b1;
    end
    if (odd) entry = half + (64'd1 << ps);
    else     entry = half;
  end

endmodule

// File: rtl/ptw_step_unit.sv
module ptw_step_unit
  import ptw_step_pkg::*;
#(
  parameter int PA_W     = 48,
  parameter int LVL_LSB  = 13,
  parameter int LVL_W    = 2,
  parameter int HUGE_BIT = 6,
  parameter int HGLB_BIT = 12,
  parameter int GLB_BIT  = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid_i,
  input  logic        op_leaf_i,
  input  logic [2:0]  op_level_i,
  input  logic        op_odd_i,
  input  logic [63:0] op_base_i,
  input  logic [63:0] fault_va_i,
  input  logic [63:0] cfg_lo_i,
  input  logic [31:0] cfg_hi_i,
  output logic        rd_req_valid_o,
  input  logic        rd_req_ready_i,
  output logic [63:0] rd_req_addr_o,
  input  logic        rd_rsp_valid_i,
  input  logic [63:0] rd_rsp_data_i,
  output logic        done_o,
  output logic [63:0] dir_result_o,
  output logic [63:0] refill_lo0_o,
  output logic [63:0] refill_lo1_o,
  output logic [5:0]  refill_ps_o
);

  localparam logic [63:0] PA_MASK = {{(64-PA_W){1'b0}}, {PA_W{1'b1}}};

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // operand decode
  logic [63:0] base_m;
  logic        base_huge;
  logic [2:0]  base_lvl;
  logic [2:0]  sel_level;
  logic        lvl_ok;
  logic [1:0]  ewc;

  assign base_m    = op_base_i & PA_MASK;
  assign base_huge = op_base_i[HUGE_BIT];
  assign base_lvl  = 3'(op_base_i[LVL_LSB +: LVL_W]);
  assign lvl_ok    = (op_level_i >= 3'd1) && (op_level_i <= 3'd4);
  assign ewc       = cfg_lo_i[EWC_LSB +: 2];

  always_comb begin
    if (!op_leaf_i)     sel_level = op_level_i;
    else if (base_huge) sel_level = base_lvl;
    else                sel_level = 3'd0;
  end

  lvl_field_t  fld;
  logic [63:0] gen_addr;
  logic [63:0] huge_entry;
  logic [5:0]  huge_ps;

  ptw_level_sel u_lvl (
    .cfg_lo (cfg_lo_i),
    .cfg_hi (cfg_hi_i),
    .level  (sel_level),
    .fld    (fld)
  );

  ptw_addr_gen u_addr (
    .base_m    (base_m),
    .va        (fault_va_i),
    .fld       (fld),
    .ewc       (ewc),
    .leaf_mode (op_leaf_i),
    .odd       (op_odd_i),
    .addr      (gen_addr)
  );

  ptw_huge_split #(
    .LVL_LSB  (LVL_LSB),
    .LVL_W    (LVL_W),
    .HUGE_BIT (HUGE_BIT),
    .HGLB_BIT (HGLB_BIT),
    .GLB_BIT  (GLB_BIT)
  ) u_huge (
    .base_m (base_m),
    .fld    (fld),
    .odd    (op_odd_i),
    .entry  (huge_entry),
    .ps     (huge_ps)
  );

  // directory step result when no read is needed
  logic [63:0] dir_direct;
  logic        needs_read;

  always_comb begin
    dir_direct = op_base_i;
    if (lvl_ok && base_huge && op_level_i != 3'd4 && base_lvl == 3'd0)
      dir_direct[LVL_LSB +: LVL_W] = op_level_i[LVL_W-1:0];
    if (op_leaf_i) needs_read = !base_huge;
    else           needs_read = lvl_ok && !base_huge;
  end

  // state and datapath registers
  ptw_state_e  state_q, state_n;
  logic [63:0] addr_q, addr_n;
  logic        addr_en;
  logic        leaf_q, odd_q, ctx_en;
  logic [5:0]  pend_ps_q;
  logic [63:0] dir_q, dir_n;
  logic        dir_en;
  logic [63:0] lo0_q, lo1_q, lo_n;
  logic        lo0_en, lo1_en;
  logic [5:0]  ps_q, ps_n;
  logic        ps_en;
  logic [63:0] rsp_m;

  assign rsp_m = rd_rsp_data_i & PA_MASK;

  always_comb begin
    state_n = state_q;
    addr_n  = gen_addr;
    addr_en = 1'b0;
    ctx_en  = 1'b0;
    dir_n   = dir_direct;
    dir_en  = 1'b0;
    lo_n    = huge_entry;
    lo0_en  = 1'b0;
    lo1_en  = 1'b0;
    ps_n    = huge_ps;
    ps_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (op_valid_i) begin
          if (needs_read) begin
            state_n = ST_REQ;
            addr_en = 1'b1;
            ctx_en  = 1'b1;
          end else begin
            state_n = ST_DONE;
            if (!op_leaf_i) begin
              dir_en = 1'b1;
            end else begin
              lo0_en = !op_odd_i;
              lo1_en = op_odd_i;
              ps_en  = 1'b1;
            end
          end
        end
      end
      ST_REQ: begin
        if (rd_req_ready_i) state_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (rd_rsp_valid_i) begin
          state_n = ST_DONE;
          dir_n   = rsp_m;
          lo_n    = rsp_m;
          ps_n    = pend_ps_q;
          if (!leaf_q) begin
            dir_en = 1'b1;
          end else begin
            lo0_en = !odd_q;
            lo1_en = odd_q;
            ps_en  = 1'b1;
          end
        end
      end
      ST_DONE: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      leaf_q    <= 1'b0;
      odd_q     <= 1'b0;
      pend_ps_q <= '0;
      dir_q     <= '0;
      lo0_q     <= '0;
      lo1_q     <= '0;
      ps_q      <= '0;
    end else begin
      state_q <= state_n;
      if (addr_en) addr_q <= addr_n;
      if (ctx_en) begin
        leaf_q    <= op_leaf_i;
        odd_q     <= op_odd_i;
        pend_ps_q <= fld.pos;
      end
      if (dir_en) dir_q <= dir_n;
      if (lo0_en) lo0_q <= lo_n;
      if (lo1_en) lo1_q <= lo_n;
      if (ps_en)  ps_q  <= ps_n;
    end
  end

  assign rd_req_valid_o = (state_q == ST_REQ);
  assign rd_req_addr_o  = addr_q;
  assign done_o         = (state_q == ST_DONE);
  assign dir_result_o   = dir_q;
  assign refill_lo0_o   = lo0_q;
  assign refill_lo1_o   = lo1_q;
  assign refill_ps_o    = ps_q;

endmodule

// File: rtl/ptw_step_chk.sv
module ptw_step_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done_o,
  input logic        rd_req_valid_o,
  input logic        rd_req_ready_i,
  input logic [63:0] rd_req_addr_o,
  input logic        rd_rsp_valid_i,
  input logic [63:0] refill_lo0_o,
  input logic [63:0] refill_lo1_o,
  input logic [5:0]  refill_ps_o
);

  logic outstanding_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                outstanding_q <= 1'b0;
    else if (rd_req_valid_o && rd_req_ready_i) outstanding_q <= 1'b1;
    else if (rd_rsp_valid_i)                   outstanding_q <= 1'b0;
  end

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o);

  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid_o && !rd_req_ready_i |=> $stable(rd_req_addr_o));

  a_r9_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding_q |-> !rd_req_valid_o);

  a_r10_done_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding_q && rd_rsp_valid_i |=> done_o);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_lo0_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(refill_lo0_o) |-> done_o);

  a_r7_lo1_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(refill_lo1_o) |-> done_o);

  a_r7_ps_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(refill_ps_o) |-> done_o);

endmodule

bind ptw_step_unit ptw_step_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .done_o         (done_o),
  .rd_req_valid_o (rd_req_valid_o),
  .rd_req_ready_i (rd_req_ready_i),
  .rd_req_addr_o  (rd_req_addr_o),
  .rd_rsp_valid_i (rd_rsp_valid_i),
  .refill_lo0_o   (refill_lo0_o),
  .refill_lo1_o   (refill_lo1_o),
  .refill_ps_o    (refill_ps_o)
);

// File: tb/sim_ptw_step_unit.sv
`timescale 1ns/1ps
module sim_ptw_step_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_leaf = 1'b0;
  logic [2:0]  op_level = '0;
  logic        op_odd = 1'b0;
  logic [63:0] op_base = '0;
  logic [63:0] fault_va = '0;
  logic [63:0] cfg_lo = '0;
  logic [31:0] cfg_hi = '0;
  logic        rdy = 1'b0;
  logic        rsp_v = 1'b0;
  logic [63:0] rsp_d = '0;
  logic        req_valid, done;
  logic [63:0] req_addr, dir_res, lo0, lo1;
  logic [5:0]  ps;

  always #4 clk = ~clk;

  ptw_step_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_leaf_i(op_leaf),
    .op_level_i(op_level), .op_odd_i(op_odd), .op_base_i(op_base),
    .fault_va_i(fault_va), .cfg_lo_i(cfg_lo), .cfg_hi_i(cfg_hi),
    .rd_req_valid_o(req_valid), .rd_req_ready_i(rdy), .rd_req_addr_o(req_addr),
    .rd_rsp_valid_i(rsp_v), .rd_rsp_data_i(rsp_d), .done_o(done),
    .dir_result_o(dir_res), .refill_lo0_o(lo0), .refill_lo1_o(lo1),
    .refill_ps_o(ps)
  );

  localparam logic [63:0] M48 = 64'h0000_FFFF_FFFF_FFFF;

  int errors = 0;
  int checks = 0;
  int n_reads = 0;
  int stall_cfg = 0;
  int lat_cfg = 0;
  logic [63:0] last_addr = '0;
  int pos_b [5];
  int wid_b [5];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_word(input logic [63:0] a);
    return {16'hBEEF, a[47:0] ^ 48'h0123_4567_89AB};
  endfunction

  function automatic logic [15:0] mk_slot(input int p, input int w);
    return {3'b000, 5'(w), 2'b00, 6'(p)};
  endfunction

  function automatic logic [63:0] exp_addr(input logic [63:0] b, input logic [63:0] va,
                                            input int lvl, input int code,
                                            input bit leaf, input bit odd);
    logic [63:0] ix;
    ix = (va >> pos_b[lvl]) & ((64'd1 << wid_b[lvl]) - 1);
    if (leaf) begin ix[0] = 1'b0; ix = ix + 64'(odd); end
    return (b & M48) | (ix << (3 * (code + 1)));
  endfunction

  function automatic logic [63:0] exp_huge(input logic [63:0] b, input bit odd,
                                            output int pgsz);
    logic [63:0] e;
    int l;
    e = b & M48;
    l = int'(e[14:13]);
    pgsz = pos_b[l] + wid_b[l] - 1;
    e[14:13] = 2'b00;
    e[6] = 1'b0;
    if (e[12]) begin e[12] = 1'b0; e[6] = 1'b1; end
    if (odd) e = e + (64'd1 << pgsz);
    return e;
  endfunction

  task automatic set_cfg(input int code);
    cfg_lo = {14'd0, 2'(code), mk_slot(pos_b[2], wid_b[2]),
              mk_slot(pos_b[1], wid_b[1]), mk_slot(pos_b[0], wid_b[0])};
    cfg_hi = {mk_slot(pos_b[4], wid_b[4]), mk_slot(pos_b[3], wid_b[3])};
  endtask

  // memory model: all activity at the falling edge
  initial begin
    bit pv, pend, rsp_prev;
    logic [63:0] pa, cap;
    int wcnt, lcnt;
    pv = 0; pend = 0; rsp_prev = 0; pa = '0; cap = '0; wcnt = 0; lcnt = 0;
    forever begin
      @(negedge clk);
      if (rsp_prev) chk(done === 1'b1, "R10 done one cycle after response", 64'(done), 64'd1);
      rsp_prev = 0;
      rsp_v = 1'b0;
      if (rdy && pv) begin
        pend = 1; cap = pa; lcnt = lat_cfg; n_reads++; last_addr = pa;
      end
      if (pend) begin
        if (lcnt == 0) begin
          rsp_v = 1'b1; rsp_d = mem_word(cap); pend = 0; rsp_prev = 1;
        end else lcnt--;
      end
      pv = req_valid;
      pa = req_addr;
      if (pv && !pend) begin
        if (wcnt >= stall_cfg) rdy = 1'b1;
        else begin rdy = 1'b0; wcnt++; end
      end else begin
        rdy = 1'b0; wcnt = 0;
      end
    end
  end

  task automatic run_op(input bit leaf, input logic [2:0] lvl, input bit odd,
                        input logic [63:0] base, input logic [63:0] va,
                        output int reads_used, output int cyc);
    int r0;
    r0 = n_reads;
    @(negedge clk);
    op_valid = 1'b1; op_leaf = leaf; op_level = lvl; op_odd = odd;
    op_base = base; fault_va = va;
    @(negedge clk);
    op_valid = 1'b0;
    cyc = 1;
    while (done !== 1'b1 && cyc < 60) begin @(negedge clk); cyc++; end
    reads_used = n_reads - r0;
  endtask

  task automatic t_reset;
    chk(done === 1'b0 && req_valid === 1'b0, "R1 reset control", {req_valid, done}, 0);
    chk(dir_res === '0 && lo0 === '0, "R1 reset dir/lo0", dir_res | lo0, 0);
    chk(lo1 === '0 && ps === '0, "R1 reset lo1/ps", lo1 | 64'(ps), 0);
  endtask

  task automatic t_dir_read(input int lvl, input int code, input int stall, input int lat);
    int rd, cy;
    logic [63:0] b, va, ea;
    logic [63:0] l0, l1;
    logic [5:0] p0;
    b  = 64'hF000_1234_5600_0000 | (64'(lvl) << 20);
    va = 64'h0000_7A5C_3E9F_1234 ^ (64'(lvl) << 33);
    stall_cfg = stall; lat_cfg = lat;
    set_cfg(code);
    l0 = lo0; l1 = lo1; p0 = ps;
    ea = exp_addr(b, va, lvl, code, 0, 0);
    run_op(0, 3'(lvl), 0, b, va, rd, cy);
    chk(rd == 1, "R2 one read issued", 64'(rd), 1);
    chk(last_addr === ea, "R2 directory address", last_addr, ea);
    chk(dir_res === (mem_word(ea) & M48), "R8 loaded word masked", dir_res, mem_word(ea) & M48);
    chk(lo0 === l0 && lo1 === l1 && ps === p0, "R7 directory step keeps refill", lo0 ^ l0, 0);
  endtask

  task automatic t_dir_bad_level(input logic [2:0] lvl);
    int rd, cy;
    logic [63:0] b;
    b = 64'hDEAD_0000_1111_2000 | 64'(lvl);
    run_op(0, lvl, 0, b, 64'h1234_5678, rd, cy);
    chk(rd == 0, "R3 no read for bad level", 64'(rd), 0);
    chk(dir_res === b, "R3 raw base returned", dir_res, b);
    chk(cy == 1, "R10 done one cycle after accept", 64'(cy), 1);
  endtask

  task automatic t_dir_huge;
    int rd, cy;
    logic [63:0] b, e;
    b = 64'hC000_0000_4000_0040;
    run_op(0, 3'd4, 0, b, 64'h55, rd, cy);
    chk(rd == 0 && dir_res === b, "R4 huge at level 4 unchanged", dir_res, b);
    b = 64'hC000_0000_4000_4040;
    run_op(0, 3'd2, 0, b, 64'h55, rd, cy);
    chk(rd == 0 && dir_res === b, "R4 huge with level set unchanged", dir_res, b);
    b = 64'hC000_0000_4000_0040;
    e = b | (64'd3 << 13);
    run_op(0, 3'd3, 0, b, 64'h55, rd, cy);
    chk(rd == 0 && dir_res === e, "R4 huge level inserted", dir_res, e);
  endtask

  task automatic t_leaf_read(input bit odd, input logic [63:0] va, input int code);
    int rd, cy;
    logic [63:0] b, ea, ew, keep;
    b = 64'hA000_0000_0BAD_0000;
    set_cfg(code);
    stall_cfg = 1; lat_cfg = 1;
    keep = odd ? lo0 : lo1;
    ea = exp_addr(b, va, 0, code, 1, odd);
    ew = mem_word(ea) & M48;
    run_op(1, 3'd0, odd, b, va, rd, cy);
    chk(rd == 1 && last_addr === ea, "R5 leaf address", last_addr, ea);
    chk((odd ? lo1 : lo0) === ew, "R7 leaf target register", odd ? lo1 : lo0, ew);
    chk((odd ? lo0 : lo1) === keep, "R7 other register kept", odd ? lo0 : lo1, keep);
    chk(ps === 6'(pos_b[0]), "R5 leaf page size", 64'(ps), 64'(pos_b[0]));
  endtask

  task automatic t_leaf_huge(input bit odd, input logic [63:0] b);
    int rd, cy, pg;
    logic [63:0] e;
    e = exp_huge(b, odd, pg);
    run_op(1, 3'd0, odd, b, 64'hFFFF_FFFF, rd, cy);
    chk(rd == 0, "R6 huge leaf no read", 64'(rd), 0);
    chk((odd ? lo1 : lo0) === e, "R6 huge split entry", odd ? lo1 : lo0, e);
    chk(ps === 6'(pg), "R6 huge page size", 64'(ps), 64'(pg));
  endtask

  task automatic t_busy_ignore;
    int rd, cy;
    logic [63:0] b, va, ea;
    b = 64'h0000_0000_7700_0000; va = 64'h0000_0012_3456_7000;
    stall_cfg = 4; lat_cfg = 3;
    set_cfg(1);
    ea = exp_addr(b, va, 1, 1, 0, 0);
    @(negedge clk);
    op_valid = 1'b1; op_leaf = 1'b0; op_level = 3'd1; op_odd = 1'b0;
    op_base = b; fault_va = va;
    @(negedge clk);
    op_level = 3'd0; op_base = 64'h1111;
    @(negedge clk);
    op_valid = 1'b0;
    cy = 0; rd = n_reads;
    while (done !== 1'b1 && cy < 60) begin @(negedge clk); cy++; end
    chk(last_addr === ea, "R9 address held through stall", last_addr, ea);
    chk(dir_res === (mem_word(ea) & M48), "R10 op during step ignored", dir_res, mem_word(ea) & M48);
    repeat (3) @(negedge clk);
    chk(req_valid === 1'b0 && done === 1'b0, "R10 no second step", {req_valid, done}, 0);
  endtask

  initial begin
    pos_b[0] = 12; wid_b[0] = 9;
    pos_b[1] = 21; wid_b[1] = 9;
    pos_b[2] = 30; wid_b[2] = 9;
    pos_b[3] = 39; wid_b[3] = 9;
    pos_b[4] = 48; wid_b[4] = 4;
    set_cfg(0);
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_dir_read(1, 0, 0, 0);
    t_dir_read(2, 2, 2, 1);
    t_dir_read(3, 3, 0, 4);
    t_dir_read(4, 1, 3, 0);
    t_dir_bad_level(3'd0);
    t_dir_bad_level(3'd5);
    t_dir_bad_level(3'd7);
    t_dir_huge;
    t_leaf_read(0, 64'h0000_0000_0012_3000, 0);
    t_leaf_read(1, 64'h0000_0000_0012_3000, 0);
    t_leaf_read(1, 64'h0000_0000_0012_2000, 2);
    t_leaf_read(0, 64'h0000_0000_001F_F000, 3);
    t_leaf_huge(0, 64'hF000_0000_4000_5040);
    t_leaf_huge(1, 64'h0F00_0000_8000_3040);
    t_leaf_huge(1, 64'h0000_0001_0000_1040);
    t_busy_ignore;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule